// File: doc/BRIEF.md
# I/O Page Table Translator

This block maps a device DMA transfer onto physical memory. A transfer is described by an I/O virtual address, a byte length and a direction. The block cuts it into pieces that each stay inside one 4 KB page. For every piece it reads one 32-bit page-table entry through a memory read port and checks the entry's permission bits. When the checks pass, it emits the 36-bit physical address and the byte count of that piece.

The table base and the window-size select come from the register block that sits next to this one. They must stay stable while a transfer is in flight. Only one table read is outstanding at a time, and the response may take any number of cycles. If a permission check fails, the block reports the page-aligned I/O address and the direction of the failing access. It then raises an abort pulse in place of the done pulse and drops the rest of the transfer.

Top module: `iopt_xlate`

## Requirements
- R1: No piece crosses a 4 KB page boundary. The first piece is the smaller of the bytes left to the end of its page and the transfer length. Each later piece is the smaller of 4096 and the bytes still left.
- R2: The window select `cfg_win_sel` = s gives a window of 2^(24+s) bytes. For each page the table read address is `{cfg_base, 4'b0000}` plus 4 × ((iova with bits 24+s and above cleared) >> 12).
- R3: The table read returns bytes in address order, with the byte at the lowest address on lane 0 (bits 7:0). The entry is the big-endian word formed from those bytes, so lane 0 becomes bits 31:24.
- R4: The entry layout is as follows: bits 31:8 are the frame number, bit 7 is cacheable, bit 2 is writable, bit 1 is valid and bit 0 is write-as-zero. The piece address is {entry[31:8], iova[11:0]}, and `chk_cache` carries entry bit 7.
- R5: An entry whose valid bit is clear causes a fault, whatever the direction.
- R6: A write through an entry whose writable bit is clear causes a fault. A read needs only the valid bit.
- R7: On a fault, `fault_valid` and `xfer_abort` pulse together. `fault_addr` is the page-aligned I/O address of the failing page and `fault_write` is the direction. No further piece of that transfer is emitted.
- R8: `req_ready` is high only while idle. At most one table read is outstanding. While `pte_rd_ready` is low, `pte_rd_valid` stays high with its address unchanged.
- R9: `xfer_done` pulses in the same cycle as the last piece. A zero-length request gives `xfer_done` one cycle after acceptance, with no table read.
- R10: After reset the block is idle: `req_ready` is high and every pulse output and `pte_rd_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Transfer request valid |
| req_ready | output | 1 | Block idle, request accepted |
| req_iova | input | 32 | I/O virtual start address |
| req_len | input | 16 | Transfer length in bytes |
| req_write | input | 1 | 1 = device writes memory |
| cfg_base | input | 32 | Table base, bytes = value × 16 |
| cfg_win_sel | input | 3 | Window size select, 16 MB << value |
| pte_rd_valid | output | 1 | Table read request |
| pte_rd_ready | input | 1 | Table read accepted |
| pte_rd_addr | output | 36 | Table entry byte address |
| pte_rsp_valid | input | 1 | Table read data valid |
| pte_rsp_data | input | 32 | Entry bytes, lowest address on lane 0 |
| chk_valid | output | 1 | Translated piece valid (one cycle) |
| chk_pa | output | 36 | Physical address of piece |
| chk_len | output | 13 | Byte count of piece |
| chk_write | output | 1 | Direction of piece |
| chk_cache | output | 1 | Cacheable bit of the entry |
| xfer_done | output | 1 | Transfer completed |
| xfer_abort | output | 1 | Transfer aborted on fault |
| fault_valid | output | 1 | Fault report strobe |
| fault_addr | output | 32 | Page-aligned I/O address of fault |
| fault_write | output | 1 | Direction of faulting access |

## Verification
A corrupted address or remaining count shows up at once: the next table read address is off, or the length of the next piece is off. The bench compares both for every page. A lane-order or field-decode fault gives a wrong physical address or cache bit in the same cycle the response lands. A state error shows up as a missing done or abort pulse, or as a piece appearing after an abort, within one response of the failing page. The stalled-read runs show that a read request dropped or changed under back-pressure corrupts the following piece.

// File: rtl/iopt_pkg.sv
package iopt_pkg;

    typedef enum logic [1:0] {
        XL_IDLE  = 2'd0,
        XL_ISSUE = 2'd1,
        XL_WAIT  = 2'd2
    } xl_state_e;

    // Page-table entry, MSB first
    typedef struct packed {
        logic [23:0] frame;
        logic        cache;
        logic [3:0]  rsvd;
        logic        wr_ok;
        logic        vld;
        logic        waz;
    } pte_t;

endpackage

// File: rtl/iopt_pte_addr.sv
module iopt_pte_addr #(
    parameter int VA_W         = 32,
    parameter int PA_W         = 36,
    parameter int SEL_W        = 3,
    parameter int WIN_MIN_LOG2 = 24,
    parameter int PAGE_SHIFT   = 12
) (
    input  logic [VA_W-1:0]   iova,
    input  logic [PA_W-5:0]   base,
    input  logic [SEL_W-1:0]  win_sel,
    output logic [PA_W-1:0]   ent_addr
);
    localparam int LIM_W = VA_W + 1;

    logic [LIM_W-1:0] lim;
    logic [VA_W-1:0]  win_mask;
    logic [VA_W-1:0]  offs;
    logic [VA_W-1:0]  idx;

    always_comb begin
        lim      = {{(LIM_W-1){1'b0}}, 1'b1} << (WIN_MIN_LOG2 + int'(win_sel));
        win_mask = VA_W'(lim - 1'b1);
        offs     = iova & win_mask;
        idx      = offs >> PAGE_SHIFT;
        ent_addr = PA_W'({base, 4'b0000}) + PA_W'({idx, 2'b00});
    end
endmodule

// File: rtl/iopt_chunk_len.sv
module iopt_chunk_len #(
    parameter int VA_W       = 32,
    parameter int LEN_W      = 16,
    parameter int PAGE_SHIFT = 12
) (
    input  logic [VA_W-1:0]     iova,
    input  logic [LEN_W-1:0]    rem,
    output logic [PAGE_SHIFT:0] clen,
    output logic                last
);
    localparam int CL_W  = PAGE_SHIFT + 1;
    localparam int CMP_W = (LEN_W > CL_W) ? LEN_W : CL_W;

    logic [CMP_W-1:0] to_end;
    logic [CMP_W-1:0] rem_w;

    always_comb begin
        to_end = (CMP_W'(1) << PAGE_SHIFT) - CMP_W'(iova[PAGE_SHIFT-1:0]);
        rem_w  = CMP_W'(rem);
        last   = (rem_w <= to_end);
        clen   = last ? CL_W'(rem_w) : CL_W'(to_end);
    end
endmodule

// File: rtl/iopt_pte_check.sv
module iopt_pte_check
    import iopt_pkg::*;
#(
    parameter int VA_W       = 32,
    parameter int PA_W       = 36,
    parameter int PAGE_SHIFT = 12,
    parameter int LANES      = 4
) (
    input  logic [8*LANES-1:0] rsp_bytes,
    input  logic [VA_W-1:0]    iova,
    input  logic               is_write,
    output logic               pass,
    output logic               cacheable,
    output logic [PA_W-1:0]    pa
);
    logic [8*LANES-1:0] word;
    pte_t               ent;

    // lane k (address + k) lands in the k-th byte from the top
    for (genvar k = 0; k < LANES; k++) begin : g_swap
        assign word[8*(LANES-k)-1 -: 8] = rsp_bytes[8*k +: 8];
    end

    always_comb begin
        ent       = pte_t'(word);
        pass      = ent.vld && (!is_write || ent.wr_ok);
        cacheable = ent.cache;
        pa        = PA_W'({ent.frame, iova[PAGE_SHIFT-1:0]});
    end
endmodule

// File: rtl/iopt_xlate.sv
module iopt_xlate
    import iopt_pkg::*;
#(
    parameter int VA_W         = 32,
    parameter int PA_W         = 36,
    parameter int LEN_W        = 16,
    parameter int SEL_W        = 3,
    parameter int WIN_MIN_LOG2 = 24,
    parameter int PAGE_SHIFT   = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [VA_W-1:0]       req_iova,
    input  logic [LEN_W-1:0]      req_len,
    input  logic                  req_write,
    input  logic [PA_W-5:0]       cfg_base,
    input  logic [SEL_W-1:0]      cfg_win_sel,
    output logic                  pte_rd_valid,
    input  logic                  pte_rd_ready,
    output logic [PA_W-1:0]       pte_rd_addr,
    input  logic                  pte_rsp_valid,
    input  logic [31:0]           pte_rsp_data,
    output logic                  chk_valid,
    output logic [PA_W-1:0]       chk_pa,
    output logic [PAGE_SHIFT:0]   chk_len,
    output logic                  chk_write,
    output logic                  chk_cache,
    output logic                  xfer_done,
    output logic                  xfer_abort,
    output logic                  fault_valid,
    output logic [VA_W-1:0]       fault_addr,
    output logic                  fault_write
);
    localparam int CL_W      = PAGE_SHIFT + 1;
    localparam int PAGE_SIZE = 1 << PAGE_SHIFT;

    typedef struct packed {
        xl_state_e           state;
        logic [VA_W-1:0]     iova;
        logic [LEN_W-1:0]    rem;
        logic                write;
        logic                chk_valid;
        logic [PA_W-1:0]     chk_pa;
        logic [CL_W-1:0]     chk_len;
        logic                chk_cache;
        logic                done;
        logic                abort;
        logic                flt_valid;
        logic [VA_W-1:0]     flt_addr;
    } regs_t;

    regs_t r_d, r_q;

    logic [CL_W-1:0] clen;
    logic            last;
    logic            pass;
    logic            cacheable;
    logic [PA_W-1:0] pa;

    iopt_pte_addr #(
        .VA_W(VA_W), .PA_W(PA_W), .SEL_W(SEL_W),
        .WIN_MIN_LOG2(WIN_MIN_LOG2), .PAGE_SHIFT(PAGE_SHIFT)
    ) u_addr (
        .iova(r_q.iova), .base(cfg_base), .win_sel(cfg_win_sel),
        .ent_addr(pte_rd_addr)
    );

    iopt_chunk_len #(
        .VA_W(VA_W), .LEN_W(LEN_W), .PAGE_SHIFT(PAGE_SHIFT)
    ) u_len (
        .iova(r_q.iova), .rem(r_q.rem), .clen(clen), .last(last)
    );

    iopt_pte_check #(
        .VA_W(VA_W), .PA_W(PA_W), .PAGE_SHIFT(PAGE_SHIFT), .LANES(4)
    ) u_chk (
        .rsp_bytes(pte_rsp_data), .iova(r_q.iova), .is_write(r_q.write),
        .pass(pass), .cacheable(cacheable), .pa(pa)
    );

    always_comb begin
        r_d           = r_q;
        r_d.chk_valid = 1'b0;
        r_d.done      = 1'b0;
        r_d.abort     = 1'b0;
        r_d.flt_valid = 1'b0;
        unique case (r_q.state)
            XL_IDLE: begin
                if (req_valid) begin
                    r_d.iova  = req_iova;
                    r_d.rem   = req_len;
                    r_d.write = req_write;
                    if (req_len == '0) r_d.done  = 1'b1;
                    else               r_d.state = XL_ISSUE;
                end
            end
            XL_ISSUE: begin
                if (pte_rd_ready) r_d.state = XL_WAIT;
            end
            XL_WAIT: begin
                if (pte_rsp_valid) begin
                    if (!pass) begin
                        r_d.flt_valid = 1'b1;
                        r_d.abort     = 1'b1;
                        r_d.flt_addr  = {r_q.iova[VA_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
                        r_d.state     = XL_IDLE;
                    end else begin
                        r_d.chk_valid = 1'b1;
                        r_d.chk_pa    = pa;
                        r_d.chk_len   = clen;
                        r_d.chk_cache = cacheable;
                        r_d.iova      = r_q.iova + VA_W'(clen);
                        r_d.rem       = r_q.rem - LEN_W'(clen);
                        if (last) begin
                            r_d.done  = 1'b1;
                            r_d.state = XL_IDLE;
                        end else begin
                            r_d.state = XL_ISSUE;
                        end
                    end
                end
            end
            default: r_d.state = XL_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= XL_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready    = (r_q.state == XL_IDLE);
    assign pte_rd_valid = (r_q.state == XL_ISSUE);
    assign chk_valid    = r_q.chk_valid;
    assign chk_pa       = r_q.chk_pa;
    assign chk_len      = r_q.chk_len;
    assign chk_write    = r_q.write;
    assign chk_cache    = r_q.chk_cache;
    assign xfer_done    = r_q.done;
    assign xfer_abort   = r_q.abort;
    assign fault_valid  = r_q.flt_valid;
    assign fault_addr   = r_q.flt_addr;
    assign fault_write  = r_q.write;

    // R1: an emitted piece is non-empty and ends inside its page
    p_page_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid |-> (chk_len != '0) &&
            ((32'(chk_pa[PAGE_SHIFT-1:0]) + 32'(chk_len)) <= PAGE_SIZE));

    // R8: a stalled read request is held with the same address
    p_fetch_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pte_rd_valid && !pte_rd_ready) |=> (pte_rd_valid && $stable(pte_rd_addr)));

    // R8: no new read is requested while the block is idle
    p_idle_no_fetch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !pte_rd_valid);

    // R7: a fault report always comes with the abort and a page-aligned address
    p_fault_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |-> (xfer_abort && (fault_addr[PAGE_SHIFT-1:0] == '0)));

    // R7: no piece follows an abort
    p_abort_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_abort |=> !chk_valid);

    // R9: a transfer ends either done or aborted, never both
    p_end_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(xfer_done && xfer_abort));

endmodule

// File: tb/test_iopt_xlate.sv
module test_iopt_xlate;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] BASE = 32'h0001_0000;
    localparam int NVEC = 7;

    typedef struct packed {
        logic [31:0] iova;
        logic [15:0] len;
        logic        wr;
        logic [2:0]  sel;
        logic [3:0]  n_chunks;
        logic        aborts;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{32'hFF00_0100, 16'h0200, 1'b0, 3'd0, 4'd1, 1'b0},
        '{32'hFF00_0F00, 16'h1400, 1'b1, 3'd0, 4'd3, 1'b0},
        '{32'h8000_2FFF, 16'h0002, 1'b0, 3'd7, 4'd2, 1'b0},
        '{32'h1E00_6000, 16'h3000, 1'b0, 3'd1, 4'd3, 1'b0},
        '{32'hFF00_5000, 16'h0010, 1'b1, 3'd0, 4'd0, 1'b1},
        '{32'hFF00_2800, 16'h1000, 1'b1, 3'd0, 4'd1, 1'b1},
        '{32'hFF00_C000, 16'h1000, 1'b0, 3'd0, 4'd0, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_iova = '0;
    logic [15:0] req_len = '0;
    logic        req_write = 1'b0;
    logic [2:0]  cfg_win_sel = '0;
    logic        pte_rd_valid;
    logic        pte_rd_ready = 1'b1;
    logic [35:0] pte_rd_addr;
    logic        pte_rsp_valid = 1'b0;
    logic [31:0] pte_rsp_data = '0;
    logic        chk_valid;
    logic [35:0] chk_pa;
    logic [12:0] chk_len;
    logic        chk_write;
    logic        chk_cache;
    logic        xfer_done;
    logic        xfer_abort;
    logic        fault_valid;
    logic [31:0] fault_addr;
    logic        fault_write;

    int  n_tests = 0;
    int  n_fail  = 0;
    int  cyc     = 0;
    bit  stall_mode = 0;
    bit  hold_ready = 0;
    bit  pend = 0;
    int  cnt = 0;
    int  mem_idx = 0;

    logic [35:0] exp_pa    [16];
    logic [12:0] exp_len   [16];
    logic        exp_cache [16];
    int          exp_n;
    bit          exp_abort;
    logic [31:0] exp_faddr;

    iopt_xlate i_iopt_xlate (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_iova(req_iova), .req_len(req_len), .req_write(req_write),
        .cfg_base(BASE), .cfg_win_sel(cfg_win_sel),
        .pte_rd_valid(pte_rd_valid), .pte_rd_ready(pte_rd_ready),
        .pte_rd_addr(pte_rd_addr),
        .pte_rsp_valid(pte_rsp_valid), .pte_rsp_data(pte_rsp_data),
        .chk_valid(chk_valid), .chk_pa(chk_pa), .chk_len(chk_len),
        .chk_write(chk_write), .chk_cache(chk_cache),
        .xfer_done(xfer_done), .xfer_abort(xfer_abort),
        .fault_valid(fault_valid), .fault_addr(fault_addr),
        .fault_write(fault_write)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // table entry i: frame, cache = i odd, writable unless i%5==3, valid unless i%7==5
    function automatic logic [31:0] tbl_word(int i);
        logic [23:0] fr;
        fr = 24'h800000 | 24'(i * 37);
        return {fr, 1'(i % 2), 4'b0000, 1'((i % 5) != 3), 1'((i % 7) != 5), 1'b0};
    endfunction

    task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // memory model: variable latency, optional stalls, bytes in address order
    always @(negedge clk) begin
        logic [31:0] w;
        logic [35:0] off;
        cyc++;
        pte_rsp_valid = 1'b0;
        pte_rd_ready  = hold_ready ? 1'b0 : (stall_mode ? ((cyc % 3) == 0) : 1'b1);
        if (pend) begin
            if (cnt == 0) begin
                w = tbl_word(mem_idx);
                pte_rsp_data  = {w[7:0], w[15:8], w[23:16], w[31:24]};
                pte_rsp_valid = 1'b1;
                pend = 0;
            end else begin
                cnt--;
            end
        end else if (rst_n && pte_rd_valid && pte_rd_ready) begin
            off = pte_rd_addr - {BASE, 4'b0000};
            check(off[1:0] == 2'b00 && off < 36'd256, "R2", "entry address in table",
                  64'(pte_rd_addr), 64'({BASE, 4'b0000}));
            mem_idx = int'(off[7:2]);
            pend = 1;
            cnt  = cyc % 3;
        end
    end

    initial begin
        int wd;
        wd = 0;
        while (wd < 100000) begin
            @(posedge clk);
            wd++;
        end
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    task automatic predict(logic [31:0] iova, logic [15:0] len, bit wr, logic [2:0] sel);
        logic [63:0] mask;
        logic [31:0] a;
        int rem, idx, clen;
        logic [31:0] w;
        mask = (64'd1 << (24 + int'(sel))) - 64'd1;
        a = iova; rem = int'(len);
        exp_n = 0; exp_abort = 0; exp_faddr = '0;
        while (rem > 0) begin
            idx  = int'((64'(a) & mask) >> 12);
            clen = 4096 - int'(a[11:0]);
            if (rem < clen) clen = rem;
            w = tbl_word(idx);
            if (!w[1] || (wr && !w[2])) begin
                exp_abort = 1;
                exp_faddr = {a[31:12], 12'h000};
                break;
            end
            exp_pa[exp_n]    = {w[31:8], a[11:0]};
            exp_len[exp_n]   = 13'(clen);
            exp_cache[exp_n] = w[7];
            exp_n++;
            a   = a + 32'(clen);
            rem = rem - clen;
        end
    endtask

    task automatic start_req(logic [31:0] iova, logic [15:0] len, bit wr, logic [2:0] sel);
        @(negedge clk);
        req_iova = iova; req_len = len; req_write = wr; cfg_win_sel = sel;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // starts at the negedge right after acceptance
    task automatic finish_xfer(bit wr, bit busy_check);
        int got;
        bit ended;
        got = 0; ended = 0;
        if (busy_check)
            check(req_ready == 1'b0, "R8", "req_ready low while busy", 64'(req_ready), 64'd0);
        for (int i = 0; i < 2000; i++) begin
            if (chk_valid) begin
                if (got < exp_n)
                    check(chk_pa == exp_pa[got] && chk_len == exp_len[got] &&
                          chk_cache == exp_cache[got] && chk_write == wr,
                          "R1/R4", "piece pa,len,cache",
                          {chk_cache, chk_len, 14'd0, chk_pa},
                          {exp_cache[got], exp_len[got], 14'd0, exp_pa[got]});
                got++;
            end
            if (xfer_done || xfer_abort) begin
                ended = 1;
                break;
            end
            @(negedge clk);
        end
        check(ended && got == exp_n, "R9", "piece count at end", 64'(got), 64'(exp_n));
        if (exp_abort)
            check(xfer_abort && !xfer_done && fault_valid && fault_addr == exp_faddr &&
                  fault_write == wr, "R5/R6/R7", "fault report",
                  {xfer_abort, fault_valid, fault_write, 29'd0, fault_addr},
                  {1'b1, 1'b1, wr, 29'd0, exp_faddr});
        else
            check(xfer_done && !xfer_abort && !fault_valid, "R9", "done pulse with last piece",
                  {62'd0, xfer_done, xfer_abort}, 64'd2);
        @(negedge clk);
        check(!chk_valid, "R7", "no piece after end", 64'(chk_valid), 64'd0);
    endtask

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        check(req_ready && !pte_rd_valid && !chk_valid && !xfer_done && !xfer_abort &&
              !fault_valid, "R10", "idle after reset",
              {58'd0, req_ready, pte_rd_valid, chk_valid, xfer_done, xfer_abort, fault_valid},
              64'h20);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk over the vector list (R1..R7, R9)
        for (int v = 0; v < NVEC; v++) begin
            predict(VECS[v].iova, VECS[v].len, VECS[v].wr, VECS[v].sel);
            check(exp_n == int'(VECS[v].n_chunks) && exp_abort == VECS[v].aborts,
                  "R1", "bench table consistency", 64'(exp_n), 64'(VECS[v].n_chunks));
            start_req(VECS[v].iova, VECS[v].len, VECS[v].wr, VECS[v].sel);
            finish_xfer(VECS[v].wr, 1);
        end

        // R8: back-pressured reads, multi-page write
        stall_mode = 1;
        predict(32'hFF00_0F00, 16'h1400, 1'b1, 3'd0);
        start_req(32'hFF00_0F00, 16'h1400, 1'b1, 3'd0);
        finish_xfer(1'b1, 1);
        stall_mode = 0;

        // R2, R3: exact entry address with out-of-window bits set, held under stall (R8)
        hold_ready = 1;
        predict(32'h5A00_2345, 16'h0004, 1'b0, 3'd0);
        start_req(32'h5A00_2345, 16'h0004, 1'b0, 3'd0);
        check(pte_rd_valid && pte_rd_addr == 36'h0_0010_0008, "R2", "entry address",
              64'(pte_rd_addr), 64'h0010_0008);
        @(negedge clk);
        check(pte_rd_valid && pte_rd_addr == 36'h0_0010_0008, "R8", "read held while stalled",
              64'(pte_rd_addr), 64'h0010_0008);
        hold_ready = 0;
        check(exp_pa[0] == 36'h8_0004_A345, "R3", "bench expected frame", 64'(exp_pa[0]),
              64'h8_0004_A345);
        finish_xfer(1'b0, 0);

        // R9: zero length
        start_req(32'hFF00_1000, 16'h0000, 1'b1, 3'd0);
        check(xfer_done && !pte_rd_valid && !chk_valid, "R9", "zero-length done, no read",
              {62'd0, xfer_done, pte_rd_valid}, 64'd2);

        // R6: read through non-writable page passes, write faults at page start
        predict(32'hFF00_3000, 16'h0800, 1'b0, 3'd0);
        start_req(32'hFF00_3000, 16'h0800, 1'b0, 3'd0);
        finish_xfer(1'b0, 1);
        predict(32'hFF00_3000, 16'h0800, 1'b1, 3'd0);
        start_req(32'hFF00_3000, 16'h0800, 1'b1, 3'd0);
        finish_xfer(1'b1, 1);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule